// File: doc/BRIEF.md
# Address-Holding One-of-Eight Decoder

This block turns a 3-bit binary select value into an 8-bit one-hot output vector. The path from the select bits to the decoder runs through an address holder. While the `freeze` input is low, the holder passes the select bits straight through in the same cycle, so the block behaves as a plain decoder. While `freeze` is high, the block ignores the select bits and decodes the address it captured in the last clock cycle in which `freeze` was low.

Two enables gate the decoded vector after the holder. One enable is active high and the other is active low. Because they have opposite polarity, either one can carry a serial data stream while the other is held active. The stream then appears only on the addressed output, so the block works as a one-to-eight demultiplexer. A parameter sets the output polarity: the selected line is either high among low lines, or low among high lines.

The holder tracks its contents with three states. `ST_VOID` means nothing has been captured since reset. `ST_LIVE` means `freeze` was low in the last cycle. `ST_HELD` means `freeze` has stayed high since the last capture. The transitions are as follows:
- Reset leads to `ST_VOID`.
- Any cycle with `freeze` low leads to `ST_LIVE`.
- `freeze` high in `ST_LIVE` or `ST_HELD` leads to `ST_HELD`.
- `freeze` high in `ST_VOID` stays in `ST_VOID`.

Top module: `addr_latch_decoder`

## Requirements
- R1: With both enables active and `freeze` low, output bit i is at its active level exactly when `sel` equals i. Bit 0 is selected by `sel`=0, and `sel` bit 0 is the least significant bit.
- R2: While `freeze` is low, the outputs follow `sel` in the same cycle, with no clock of delay.
- R3: While `freeze` is high, changes on `sel` have no effect. The outputs decode the `sel` value present in the last clock cycle in which `freeze` was low, including when `sel` changes in the cycle `freeze` rises.
- R4: When `en_act_lo_n` is 1, every output is at its inactive level, whatever the values of `freeze` and `sel`.
- R5: When `en_act_hi` is 0, every output is at its inactive level, whatever the values of `freeze` and `sel`.
- R6: With `ACTIVE_LOW`=1, the selected output is 0 and the other seven are 1. With `ACTIVE_LOW`=0, the selected output is 1 and the other seven are 0. When decoding, exactly one bit differs from the inactive level.
- R7: Switching the enables off and on while `freeze` stays high does not change the captured address.
- R8: After reset, and before any cycle with `freeze` low, holding `freeze` high gives all outputs at their inactive level.
- R9: If one enable is held active and a data stream is driven on the other, the addressed output carries the stream (inverted for `ACTIVE_LOW`=1) and the other outputs stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for address capture |
| rst_n | input | 1 | Active-low reset of the holder state |
| freeze | input | 1 | High keeps the captured address; low passes `sel` through |
| sel | input | SEL_W | Binary select value |
| en_act_hi | input | 1 | Active-high enable |
| en_act_lo_n | input | 1 | Active-low enable |
| dec_out | output | 2**SEL_W | Decoded output vector |

## Verification
Address capture and a change of the select value can fall in the same cycle: at the rising edge of `freeze`, `sel` is moved to a new value. The outputs must still show the value from the previous cycle. Enable gating can also coincide with the hold: the enables are toggled every cycle while `freeze` stays high and `sel` keeps moving. The behavioural reference in the bench judges each cycle from its own record of the last captured address, and it does so for both polarity variants side by side.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
    typedef enum logic [1:0] {
        ST_VOID = 2'd0,
        ST_LIVE = 2'd1,
        ST_HELD = 2'd2
    } hold_st_e;
endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] addr_o,
    output logic             addr_ok_o
);
    import ldec_pkg::*;

    hold_st_e         state_q, state_d;
    logic [SEL_W-1:0] held_q;

    // Captured address: loads every cycle the holder is open, never reset.
    always_ff @(posedge clk) begin
        if (!freeze) held_q <= sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_VOID;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VOID: state_d = freeze ? ST_VOID : ST_LIVE;
            ST_LIVE: state_d = freeze ? ST_HELD : ST_LIVE;
            ST_HELD: state_d = freeze ? ST_HELD : ST_LIVE;
            default: state_d = ST_VOID;
        endcase
    end

    always_comb begin
        if (!freeze) begin
            addr_o    = sel_i;
            addr_ok_o = 1'b1;
        end else begin
            addr_o    = held_q;
            addr_ok_o = (state_q != ST_VOID);
        end
    end
endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
    parameter int SEL_W = 3,
    localparam int N_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr_i,
    input  logic             ok_i,
    output logic [N_OUT-1:0] hot_o
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign hot_o[i] = ok_i && (addr_i == SEL_W'(i));
    end
endmodule

// File: rtl/ldec_out_gate.sv
module ldec_out_gate #(
    parameter int N_OUT      = 8,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [N_OUT-1:0] hot_i,
    input  logic             en_hi,
    input  logic             en_lo_n,
    output logic [N_OUT-1:0] y_o
);
    logic             pass;
    logic [N_OUT-1:0] gated;

    assign pass  = en_hi & ~en_lo_n;
    assign gated = hot_i & {N_OUT{pass}};

    if (ACTIVE_LOW) begin : g_inv
        assign y_o = ~gated;
    end else begin : g_true
        assign y_o = gated;
    end
endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder #(
    parameter int SEL_W      = 3,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freeze,
    input  logic [SEL_W-1:0]        sel,
    input  logic                    en_act_hi,
    input  logic                    en_act_lo_n,
    output logic [(1<<SEL_W)-1:0]   dec_out
);
    localparam int N_OUT = 1 << SEL_W;

    logic [SEL_W-1:0] addr;
    logic             addr_ok;
    logic [N_OUT-1:0] hot;

    ldec_addr_hold #(.SEL_W(SEL_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (freeze),
        .sel_i     (sel),
        .addr_o    (addr),
        .addr_ok_o (addr_ok)
    );

    ldec_onehot #(.SEL_W(SEL_W)) u_dec (
        .addr_i (addr),
        .ok_i   (addr_ok),
        .hot_o  (hot)
    );

    ldec_out_gate #(.N_OUT(N_OUT), .ACTIVE_LOW(ACTIVE_LOW)) u_gate (
        .hot_i   (hot),
        .en_hi   (en_act_hi),
        .en_lo_n (en_act_lo_n),
        .y_o     (dec_out)
    );
endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
    parameter int SEL_W      = 3,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  freeze,
    input logic [SEL_W-1:0]      sel,
    input logic                  en_act_hi,
    input logic                  en_act_lo_n,
    input logic [(1<<SEL_W)-1:0] dec_out
);
    localparam int N_OUT = 1 << SEL_W;
    localparam logic [N_OUT-1:0] IDLE = ACTIVE_LOW ? {N_OUT{1'b1}} : {N_OUT{1'b0}};

    logic live;
    assign live = en_act_hi && !en_act_lo_n;

    a_r4_lo_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        en_act_lo_n |-> (dec_out == IDLE));

    a_r5_hi_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act_hi |-> (dec_out == IDLE));

    a_r2_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !freeze) |-> (dec_out[sel] != IDLE[sel]));

    a_r6_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !freeze) |-> ($countones(dec_out ^ IDLE) == 1));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && $past(freeze) && live && $past(live)) |-> $stable(dec_out));
endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(
    .SEL_W(SEL_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (.*);

// File: tb/tb_addr_latch_decoder.sv
module tb_addr_latch_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frz = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       eh = 1'b1;
    logic       el_n = 1'b0;
    logic [7:0] y_hi, y_lo;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_held = 0;
    bit m_valid = 0;

    always #5 clk = ~clk;

    addr_latch_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .freeze(frz), .sel(sel),
        .en_act_hi(eh), .en_act_lo_n(el_n), .dec_out(y_hi));

    addr_latch_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b1)) dut_inv (
        .clk(clk), .rst_n(rst_n), .freeze(frz), .sel(sel),
        .en_act_hi(eh), .en_act_lo_n(el_n), .dec_out(y_lo));

    always @(posedge clk) begin
        if (!rst_n) m_valid = 0;
        else if (!frz) begin
            m_held  = int'(sel);
            m_valid = 1;
        end
    end

    function automatic logic [7:0] model(input bit inv);
        logic [7:0] v = 8'h00;
        if (eh && !el_n) begin
            if (!frz)         v[sel] = 1'b1;
            else if (m_valid) v[m_held] = 1'b1;
        end
        return inv ? ~v : v;
    endfunction

    task automatic cyc(input bit f, input logic [2:0] s, input bit h,
                       input bit ln, input string tag);
        logic [7:0] e1, e2;
        @(negedge clk);
        frz = f; sel = s; eh = h; el_n = ln;
        #4;
        e1 = model(1'b0);
        e2 = model(1'b1);
        total++;
        if (y_hi !== e1) begin
            bad++;
            $display("FAIL %s true-polarity y=%b exp=%b", tag, y_hi, e1);
        end
        total++;
        if (y_lo !== e2) begin
            bad++;
            $display("FAIL R6/%s inverted y=%b exp=%b", tag, y_lo, e2);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset and just after, nothing captured yet
        cyc(1, 3'd2, 1, 0, "R8");
        cyc(1, 3'd6, 1, 0, "R8");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 3'd1, 1, 0, "R8");
        cyc(1, 3'd7, 1, 0, "R8");
        // R1/R4/R5: sweep all addresses under all enable pairs
        for (int e = 0; e < 4; e++) begin
            for (int a = 0; a < 8; a++) begin
                cyc(0, 3'(a), e[1], e[0],
                    (e == 2) ? "R1" : (e[0] ? "R4" : "R5"));
            end
        end
        // R3: capture 5, then sel moves in the very cycle freeze rises
        cyc(0, 3'd5, 1, 0, "R3");
        for (int a = 0; a < 8; a++) cyc(1, 3'(a), 1, 0, "R3");
        // R4/R5 with freeze high and low
        cyc(1, 3'd2, 1, 1, "R4");
        cyc(0, 3'd2, 0, 0, "R5");
        // R7: enables toggle while held
        cyc(0, 3'd6, 1, 0, "R7");
        for (int k = 0; k < 8; k++)
            cyc(1, 3'(k * 3), k[0], k[1], "R7");
        cyc(1, 3'd0, 1, 0, "R7");
        // R2: freeze low, sel changes every cycle
        for (int k = 0; k < 8; k++) cyc(0, 3'(7 - k), 1, 0, "R2");
        // R9: data on the active-high enable, then on the active-low one
        begin
            logic [7:0] stream = 8'b1011_0010;
            for (int k = 0; k < 8; k++) cyc(0, 3'd3, stream[k], 0, "R9");
            for (int k = 0; k < 8; k++) cyc(1, 3'd6, 1, ~stream[k], "R9");
        end
        // R8 again after a reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        cyc(1, 3'd4, 1, 0, "R8");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 3'd4, 1, 0, "R8");
        cyc(0, 3'd4, 1, 0, "R2");
        cyc(1, 3'd1, 1, 0, "R3");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule